// File: doc/BRIEF.md
# Multi-Image Boot Header Streamer

This block generates, one byte at a time, the boot-selection header that sits at the very start of an FPGA configuration flash. The header holds five entries of 32 bytes each. The first entry names the image loaded at power-up. The other four name the images for the four warm-boot selector codes. Each entry carries a 24-bit image start address.

A single `start` pulse snapshots the five offsets and their valid flags. The block then presents 160 bytes on a valid/ready byte port, in order. A flash programmer or a buffer consumes the bytes at whatever pace it likes. When the last byte has been taken, `done` rises and stays high until the next start.

Each entry has a fixed command grammar. The low nibble of each command opcode is the number of argument bytes that follow it, except in the leading sync word. Any entry whose offset is not flagged valid takes the offset of entry 0.

Top module: `boot_hdr_stream`

## Requirements
- R1: After reset, `out_valid` and `done` are both 0.
- R2: Within every entry, bytes 0..8 are 7E AA 99 7E 92 00 00 44 03. Bytes 12..16 are 82 00 00 01 08. The third byte of the mode command (byte 6) is 00, which selects warm boot. The first byte presented after a start is 7E.
- R3: Entry bytes 9, 10 and 11 carry that entry's 24-bit address, most significant byte first.
- R4: Entry bytes 17..31 are 00.
- R5: Entries go out in order: entry 0 (power-up image), then slots 1 to 4, which are selector codes 00, 01, 10 and 11. Entry e uses offset bits `[24*e+23:24*e]`.
- R6: An entry e ≥ 1 whose `offs_vld[e]` is 0 carries the entry-0 offset. Entry 0 always uses its own offset, whatever `offs_vld[0]` is.
- R7: The byte index advances only on a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` stays unchanged on the next cycle.
- R8: Exactly 160 bytes are accepted per run. On the cycle after the 160th acceptance, `done` is 1 and `out_valid` is 0. `out_valid` and `done` are never both 1.
- R9: A `start` pulse that arrives while `out_valid` is 1 has no effect. This includes a pulse on the cycle of the final acceptance.
- R10: Offsets and valid flags are sampled on the start cycle. Changes to them during a run do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored while busy |
| offs | input | 120 | Five 24-bit offsets, entry 0 in the low bits |
| offs_vld | input | 5 | Per-entry offset valid flags |
| out_data | output | 8 | Current header byte |
| out_valid | output | 1 | Byte available (busy) |
| out_ready | input | 1 | Consumer accepts the byte when high with out_valid |
| done | output | 1 | High after the last byte has been accepted |

## Verification
Two events can fall on the same clock edge: the acceptance of the final byte, which ends the run, and a new `start` pulse. The bench raises `start` on exactly the cycle where it accepts byte 159, and also raises it mid-stream while `out_ready` is being toggled. It judges the outcome by three things: exactly 160 bytes arrive, `done` rises, and `out_valid` stays low afterwards with no second run beginning. Stalls that occur at the same time as a start pulse are checked separately, by confirming that the held byte does not change.

// File: rtl/boot_hdr_stream.sv
module boot_hdr_stream #(
  parameter int ENTRIES     = 5,
  parameter int ENTRY_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ENTRIES*24-1:0] offs,
  input  logic [ENTRIES-1:0]    offs_vld,
  output logic [7:0]            out_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  done
);
  localparam int TOTAL = ENTRIES * ENTRY_BYTES;
  localparam int PW    = $clog2(ENTRY_BYTES);
  localparam int EW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic                    busy;
  logic [PW-1:0]           pos;
  logic [EW-1:0]           ent;
  logic [ENTRIES-1:0][23:0] addr_q;
  logic [23:0]             cur_addr;
  logic                    fire, last, kick;

  assign out_valid = busy;
  assign fire      = busy & out_ready;
  assign kick      = start & ~busy;
  assign last      = (ent == EW'(ENTRIES - 1)) && (pos == PW'(ENTRY_BYTES - 1));
  assign cur_addr  = addr_q[ent];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_q[e] <= '0;
      else if (kick)
        addr_q[e] <= (e == 0 || offs_vld[e]) ? offs[e*24 +: 24] : offs[23:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pos  <= '0;
      ent  <= '0;
    end else if (kick) begin
      busy <= 1'b1;
      done <= 1'b0;
      pos  <= '0;
      ent  <= '0;
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (pos == PW'(ENTRY_BYTES - 1)) begin
        pos <= '0;
        ent <= ent + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    case (pos)
      PW'(0):  out_data = 8'h7E;
      PW'(1):  out_data = 8'hAA;
      PW'(2):  out_data = 8'h99;
      PW'(3):  out_data = 8'h7E;
      PW'(4):  out_data = 8'h92;
      PW'(5):  out_data = 8'h00;
      PW'(6):  out_data = 8'h00;
      PW'(7):  out_data = 8'h44;
      PW'(8):  out_data = 8'h03;
      PW'(9):  out_data = cur_addr[23:16];
      PW'(10): out_data = cur_addr[15:8];
      PW'(11): out_data = cur_addr[7:0];
      PW'(12): out_data = 8'h82;
      PW'(13): out_data = 8'h00;
      PW'(14): out_data = 8'h00;
      PW'(15): out_data = 8'h01;
      PW'(16): out_data = 8'h08;
      default: out_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/boot_hdr_stream_chk.sv
module boot_hdr_stream_chk #(
  parameter int TOTAL = 160
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done
);
  logic [15:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc <= '0;
    else if (start && !out_valid)
      acc <= '0;
    else if (out_valid && out_ready)
      acc <= acc + 16'd1;
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r8_count_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> acc == 16'(TOTAL));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid));

  a_r2_first_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == 8'h7E);

  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && start |=> out_valid);
endmodule

bind boot_hdr_stream boot_hdr_stream_chk #(.TOTAL(TOTAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .done(done)
);

// File: tb/sim_boot_hdr_stream.sv
module sim_boot_hdr_stream;
  localparam int CLK_PERIOD = 10;
  localparam int N = 160;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [119:0] offs = '0;
  logic [4:0]   offs_vld = '0;
  logic [7:0]   out_data;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic         done;

  int n_run = 0, n_fail = 0;
  logic [7:0] got [N];
  int n_got;
  int stall_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_hdr_stream u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .offs(offs), .offs_vld(offs_vld),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_b(input int p, input logic [23:0] a);
    case (p)
      0: return 8'h7E;  1: return 8'hAA;  2: return 8'h99;  3: return 8'h7E;
      4: return 8'h92;  5: return 8'h00;  6: return 8'h00;  7: return 8'h44;
      8: return 8'h03;  9: return a[23:16]; 10: return a[15:8]; 11: return a[7:0];
      12: return 8'h82; 13: return 8'h00; 14: return 8'h00; 15: return 8'h01;
      16: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic collect(input bit stall, input int start_at);
    logic [7:0] prev = '0;
    bit hold = 0;
    bit fin = 0;
    bit rdy;
    n_got = 0; stall_bad = 0;
    for (int c = 0; c < 3000 && !fin; c++) begin
      if (c > 0) @(negedge clk);
      if (done) begin
        fin = 1; start = 1'b0; out_ready = 1'b0;
      end else begin
        if (hold && out_data !== prev) stall_bad++;
        start = (start_at >= 0 && n_got == start_at);
        rdy = stall ? (c % 3 != 1) : 1'b1;
        out_ready = rdy;
        if (out_valid && rdy && n_got < N) begin
          got[n_got] = out_data;
          n_got++;
        end
        hold = out_valid && !rdy;
        prev = out_data;
      end
    end
    chk(fin, "R8 watchdog/done", fin, 1);
  endtask

  task automatic verify(input logic [23:0] a [5], input string areq);
    int b2 = 0, b3 = 0, b4 = 0;
    for (int i = 0; i < N; i++) begin
      int p = i % 32;
      logic [7:0] e = exp_b(p, a[i/32]);
      if (got[i] !== e) begin
        if (p >= 9 && p <= 11) b3++;
        else if (p >= 17) b4++;
        else b2++;
      end
    end
    chk(n_got == N, "R8 byte count", n_got, N);
    chk(b2 == 0, "R2 command bytes mismatches", b2, 0);
    chk(b3 == 0, areq, b3, 0);
    chk(b4 == 0, "R4 padding mismatches", b4, 0);
    chk(done && !out_valid, "R8 done/valid after run", {done, out_valid}, 2'b10);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid && !done, "R1 reset state", {out_valid, done}, 0);
  endtask

  task automatic t_all_valid();
    logic [23:0] a [5] = '{24'h0000A0, 24'h040000, 24'h12_34_56, 24'hABCDEF, 24'hFEDCBA};
    for (int e = 0; e < 5; e++) offs[e*24 +: 24] = a[e];
    offs_vld = 5'b11111;
    kick();
    chk(out_valid && out_data == 8'h7E, "R2 first byte", out_data, 8'h7E);
    collect(0, -1);
    verify(a, "R3 R5 address bytes mismatches");
  endtask

  task automatic t_missing_stall();
    logic [23:0] a [5];
    offs = {24'h555555, 24'h444444, 24'h333333, 24'h222222, 24'h010203};
    offs_vld = 5'b10100;
    a = '{24'h010203, 24'h010203, 24'h333333, 24'h010203, 24'h555555};
    kick();
    collect(1, -1);
    verify(a, "R6 fallback address mismatches");
    chk(stall_bad == 0, "R7 byte changed during stall", stall_bad, 0);
  endtask

  task automatic t_start_busy();
    logic [23:0] a [5] = '{24'h0A0B0C, 24'h0A0B0C, 24'h0A0B0C, 24'h0A0B0C, 24'h0A0B0C};
    offs = {5{24'h0A0B0C}};
    offs_vld = 5'b00001;
    kick();
    collect(1, 40);
    verify(a, "R9 mid-run start address mismatches");
    chk(stall_bad == 0, "R9 R7 stall with start", stall_bad, 0);
    kick();
    collect(0, N - 1);
    verify(a, "R9 last-byte start mismatches");
    repeat (4) @(negedge clk);
    chk(!out_valid && done, "R9 no restart after overlap", {out_valid, done}, 2'b01);
  endtask

  task automatic t_capture();
    logic [23:0] a [5] = '{24'h112233, 24'h445566, 24'h778899, 24'hAABBCC, 24'hDDEEFF};
    for (int e = 0; e < 5; e++) offs[e*24 +: 24] = a[e];
    offs_vld = 5'b11111;
    kick();
    offs = {5{24'hFFFFFF}};
    offs_vld = 5'b00000;
    collect(1, -1);
    verify(a, "R10 captured address mismatches");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_all_valid();
    t_missing_stall();
    t_start_busy();
    t_capture();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule